// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a synchronous host to an external asynchronous static RAM of 128K words by 8 bits. The host offers one word at a time through a valid/ready request that carries an address, write data and a direction bit. The controller turns each request into the strobe sequence the RAM needs: a low-active and a high-active chip enable, a low-active output enable and a low-active write enable, plus an enable for the tri-state driver on the shared data bus. A completed read returns the captured byte with a one-clock valid pulse.

Every timing limit of the RAM is given in nanoseconds as a parameter, together with the clock frequency. At elaboration each limit becomes a cycle count, rounded up, with at least one cycle for each strobe phase. Write pulses are framed by write enable alone while the chip stays enabled. The address changes only while the chip is deselected. After a read, the controller waits for the RAM's output driver to float before it drives write data.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and in every idle cycle, the low-active chip enable is 1, the high-active chip enable is 0, output enable and write enable are 1, the bus drive enable is 0 and `req_ready` is 1.
- R2: A read enables the chip (low-active enable 0, high-active enable 1) in the cycle after the accept edge, holds write enable at 1, and drives output enable low for exactly W+1 cycles starting one cycle later. Here W = max(AA-2, OE-1, CYC-2, 1), where each of AA, OE and CYC is ceil(ns x MHz / 1000) with a minimum of 1. With the default parameters W = 4.
- R3: `rsp_rdata` holds the bus value sampled at the clock edge that ends the last output-enable-low cycle. `rsp_valid` is 1 for exactly one cycle, seen after the (W+2)th edge that follows the accept edge.
- R4: A write drives data at least one cycle before write enable falls. Write enable is low for exactly P cycles, with P = max(WP, AS-1, DS-1, CYC-2, 1); the default is 5. Data and address stay driven for one cycle after write enable rises. Output enable stays 1 in every write cycle.
- R5: The RAM address changes only on an accept edge, leaving a cycle in which the chip was deselected and write enable was 1. At least CYC cycles pass between address changes.
- R6: After a read, the bus drive enable stays 0 for at least HZ cycles after output enable rises (default HZ = 2).
- R7: `req_ready` is 1 only in idle. A request held valid, or changed, while an access is in progress is not taken and does not touch the RAM.
- R8: The bus drive enable is never 1 in a cycle where output enable is 0.
- R9: A byte written to an address is read back unchanged from that address anywhere in the 17-bit range, including all-zero, all-one, walking-one and walking-zero addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and taking requests |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | 8 | Captured read data |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, low-active |
| mem_ce | output | 1 | RAM chip enable, high-active |
| mem_oe_n | output | 1 | RAM output enable, low-active |
| mem_we_n | output | 1 | RAM write enable, low-active |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_drive | output | 1 | Tri-state enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data from the RAM bus |

## Verification
Every cycle, the assertions check the strobe exclusions: write enable and output enable are never low together, the bus is never driven while output enable is low or in the cycle it rises, and the address moves only out of a deselected cycle. They also check that data is held past the rise of write enable and that the read-valid pulse lasts one clock. Whether the wait and pulse lengths really meet the nanosecond limits, whether the turnaround after a read is long enough, and whether data survives the round trip can only be shown by the bench's RAM model. That model sweeps walking address patterns through write, read and read-then-write sequences.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_SETUP,
      ST_RD_WAIT,
      ST_RD_CAPT,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_HOLD
   } sram_state_e;

   // nanoseconds to clock cycles, rounded up, never below one cycle
   function automatic int ns_to_cycles(input int ns, input int clk_mhz);
      int c;
      c = (ns * clk_mhz + 999) / 1000;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= len - 1'b1;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

   // a loaded phase length is never zero
   assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (len != '0));

endmodule

// File: rtl/sram_float_guard.sv
module sram_float_guard #(
   parameter int HOLD_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic clear
);

   localparam int HW = $clog2(HOLD_CYC + 1);

   logic [HW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (arm) begin
         cnt_q <= HW'(HOLD_CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign clear = (cnt_q == '0);

   initial assert (HOLD_CYC >= 1) else $error("float hold must be at least one cycle");

   // arming always blocks the bus in the following cycle
   assert_arm_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> !clear);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W          = 17,
   parameter int DATA_W          = 8,
   parameter int CLK_MHZ         = 100,
   parameter int T_CYCLE_NS      = 55,
   parameter int T_ADDR_ACC_NS   = 55,
   parameter int T_OE_ACC_NS     = 25,
   parameter int T_WE_PULSE_NS   = 45,
   parameter int T_ADDR_SETUP_NS = 45,
   parameter int T_DATA_SETUP_NS = 25,
   parameter int T_FLOAT_NS      = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_ce,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_drive,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int CYC_C = ns_to_cycles(T_CYCLE_NS, CLK_MHZ);
   localparam int AA_C  = ns_to_cycles(T_ADDR_ACC_NS, CLK_MHZ);
   localparam int OE_C  = ns_to_cycles(T_OE_ACC_NS, CLK_MHZ);
   localparam int WP_C  = ns_to_cycles(T_WE_PULSE_NS, CLK_MHZ);
   localparam int AS_C  = ns_to_cycles(T_ADDR_SETUP_NS, CLK_MHZ);
   localparam int DS_C  = ns_to_cycles(T_DATA_SETUP_NS, CLK_MHZ);
   localparam int HZ_C  = ns_to_cycles(T_FLOAT_NS, CLK_MHZ);

   // read: setup(1) + wait(W) + capture(1) must cover access and cycle time
   localparam int RD_WAIT_C  = imax(imax(AA_C - 2, OE_C - 1), imax(CYC_C - 2, 1));
   // write: setup(>=1) + pulse(P) + hold(1)
   localparam int WR_PULSE_C = imax(imax(WP_C, AS_C - 1), imax(DS_C - 1, imax(CYC_C - 2, 1)));
   localparam int MAX_PH     = imax(RD_WAIT_C, WR_PULSE_C);
   localparam int CNT_W      = $clog2(MAX_PH + 1);

   initial assert (ADDR_W > 0 && DATA_W > 0 && CLK_MHZ > 0)
      else $error("address width, data width and clock rate must be positive");
   initial assert (T_CYCLE_NS >= 0 && T_ADDR_ACC_NS >= 0 && T_OE_ACC_NS >= 0 &&
                   T_WE_PULSE_NS >= 0 && T_ADDR_SETUP_NS >= 0 &&
                   T_DATA_SETUP_NS >= 0 && T_FLOAT_NS >= 0)
      else $error("timing limits must not be negative");

   sram_state_e st_q, st_d;

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              rvalid_q;
   logic              accept;
   logic              tmr_start;
   logic [CNT_W-1:0]  tmr_len;
   logic              tmr_done;
   logic              bus_clear;
   logic              in_write;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:     if (accept) st_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
         ST_RD_SETUP: st_d = ST_RD_WAIT;
         ST_RD_WAIT:  if (tmr_done) st_d = ST_RD_CAPT;
         ST_RD_CAPT:  st_d = ST_IDLE;
         ST_WR_SETUP: if (bus_clear) st_d = ST_WR_PULSE;
         ST_WR_PULSE: if (tmr_done) st_d = ST_WR_HOLD;
         ST_WR_HOLD:  st_d = ST_IDLE;
         default:     st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         addr_q   <= '0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         rvalid_q <= (st_q == ST_RD_CAPT);
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (st_q == ST_RD_CAPT) begin
            rdata_q <= mem_dq_in;
         end
      end
   end

   assign tmr_start = (st_q == ST_RD_SETUP) || ((st_q == ST_WR_SETUP) && bus_clear);
   assign tmr_len   = (st_q == ST_RD_SETUP) ? CNT_W'(RD_WAIT_C) : CNT_W'(WR_PULSE_C);

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_start),
      .len   (tmr_len),
      .done  (tmr_done)
   );

   sram_float_guard #(.HOLD_CYC(HZ_C)) u_guard (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (st_q == ST_RD_CAPT),
      .clear (bus_clear)
   );

   assign in_write     = (st_q == ST_WR_SETUP) || (st_q == ST_WR_PULSE) || (st_q == ST_WR_HOLD);
   assign mem_addr     = addr_q;
   assign mem_dq_out   = wdata_q;
   assign mem_ce_n     = (st_q == ST_IDLE);
   assign mem_ce       = (st_q != ST_IDLE);
   assign mem_oe_n     = !((st_q == ST_RD_WAIT) || (st_q == ST_RD_CAPT));
   assign mem_we_n     = (st_q != ST_WR_PULSE);
   assign mem_dq_drive = in_write && bus_clear;
   assign rsp_valid    = rvalid_q;
   assign rsp_rdata    = rdata_q;

   assert_ready_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_drive));

   assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_no_oe_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && mem_dq_drive));

   assert_hold_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_drive && $stable(mem_addr) && !mem_ce_n));

   assert_addr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mem_addr) |-> ($past(mem_ce_n) && $past(mem_we_n)));

   assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready);

   assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_drive |-> (mem_oe_n && $past(mem_oe_n)));

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

   localparam int AW = 17;
   localparam int DW = 8;
   localparam int MHZ = 100;

   function automatic int to_cyc(input int ns);
      int c;
      c = (ns * MHZ + 999) / 1000;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int CYC_C = to_cyc(55);
   localparam int AA_C  = to_cyc(55);
   localparam int OE_C  = to_cyc(25);
   localparam int WP_C  = to_cyc(45);
   localparam int AS_C  = to_cyc(45);
   localparam int DS_C  = to_cyc(25);
   localparam int HZ_C  = to_cyc(20);
   localparam int W_EXP = mx(mx(AA_C - 2, OE_C - 1), mx(CYC_C - 2, 1));
   localparam int P_EXP = mx(mx(WP_C, AS_C - 1), mx(DS_C - 1, mx(CYC_C - 2, 1)));
   localparam int NADDR = 36;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_drive;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in = '0;

   int n_checks = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   sram_async_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // ---------------- cycle-level RAM model ----------------
   logic [7:0] model_mem [int];
   logic [AW-1:0] p_addr;
   logic [DW-1:0] p_dout;
   logic p_ce_n, p_we_n, p_oe_n, p_drive;
   int addr_age, en_age, oe_age, data_age, we_low, drv_hold, since_oe;
   bit rd_seen;
   int we_falls = 0;

   always @(negedge clk) begin
      logic en;
      logic [7:0] v;
      if (!rst_n) begin
         p_addr = mem_addr; p_dout = mem_dq_out;
         p_ce_n = 1'b1; p_we_n = 1'b1; p_oe_n = 1'b1; p_drive = 1'b0;
         addr_age = 1000; en_age = 0; oe_age = 0; data_age = 0; we_low = 0;
         drv_hold = 0; since_oe = 1000; rd_seen = 1'b0;
      end else begin
         en = !mem_ce_n && mem_ce;
         if (!mem_we_n && p_we_n) begin
            we_falls++;
            chk(p_drive, "R4 data driven before write pulse", p_drive, 1);
         end
         if (mem_we_n && !p_we_n) begin
            chk(we_low == P_EXP, "R4 write pulse width", we_low, P_EXP);
            chk(addr_age >= AS_C, "R4 address setup to write end", addr_age, AS_C);
            chk(data_age >= DS_C, "R4 data setup to write end", data_age, DS_C);
            chk(mem_dq_drive, "R4 data held after write end", mem_dq_drive, 1);
            model_mem[int'(p_addr)] = p_dout;
         end
         if (!mem_we_n) chk(mem_oe_n, "R4 output enable high during write", mem_oe_n, 1);
         if (mem_addr != p_addr) begin
            chk(p_ce_n && p_we_n, "R5 address moved while selected", {p_ce_n, p_we_n}, 3);
            chk(addr_age >= CYC_C, "R5 access cycle time", addr_age, CYC_C);
         end
         if (mem_dq_drive) begin
            chk(mem_oe_n, "R8 drive with output enable low", mem_oe_n, 1);
            chk(drv_hold == 0, "R6 RAM output not yet floated", drv_hold, 0);
         end
         if (mem_oe_n && !p_oe_n)
            chk(oe_age == W_EXP + 1, "R2 output enable low width", oe_age, W_EXP + 1);
         // age bookkeeping
         addr_age = (mem_addr == p_addr) ? addr_age + 1 : 1;
         en_age   = en ? en_age + 1 : 0;
         oe_age   = !mem_oe_n ? oe_age + 1 : 0;
         we_low   = !mem_we_n ? we_low + 1 : 0;
         data_age = mem_dq_drive ? ((p_drive && mem_dq_out == p_dout) ? data_age + 1 : 1) : 0;
         since_oe = !mem_oe_n ? 0 : since_oe + 1;
         if (!mem_oe_n) rd_seen = 1'b1;
         if (mem_dq_drive && !p_drive && rd_seen) begin
            chk(since_oe - 1 >= HZ_C, "R6 turnaround after read", since_oe - 1, HZ_C);
            rd_seen = 1'b0;
         end
         if (en && mem_we_n && !mem_oe_n) drv_hold = HZ_C;
         else if (drv_hold > 0) drv_hold--;
         // read data toward the controller
         if (en && mem_we_n && !mem_oe_n) begin
            v = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h5A;
            mem_dq_in = (addr_age >= AA_C && en_age >= AA_C && oe_age >= OE_C) ? v : ~v;
         end else begin
            mem_dq_in = 8'h00;
         end
         p_addr = mem_addr; p_dout = mem_dq_out;
         p_ce_n = mem_ce_n; p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_drive = mem_dq_drive;
      end
   end

   // ---------------- host side ----------------
   function automatic logic [AW-1:0] pick_addr(input int i);
      logic [AW-1:0] one;
      one = {{(AW-1){1'b0}}, 1'b1};
      if (i < AW) return one << i;
      if (i < 2 * AW) return ~(one << (i - AW));
      if (i == 2 * AW) return '0;
      return '1;
   endfunction

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input logic [DW-1:0] seed);
      return (a[7:0] ^ a[15:8] ^ {7'd0, a[16]}) + seed;
   endfunction

   task automatic check_idle(input string tag);
      chk(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_drive && req_ready,
          tag, {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_drive, req_ready}, 6'b101101);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready && !mem_ce_n && mem_ce && mem_addr == a, "R7 busy after write accept",
          {req_ready, mem_ce_n}, 0);
      while (!req_ready) @(negedge clk);
      check_idle("R1 idle after write");
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
      int n;
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!mem_ce_n && mem_ce && mem_we_n && mem_oe_n && mem_addr == a,
          "R2 first read cycle strobes", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n}, 4'b0111);
      n = 1;
      while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
      chk(n - 1 == W_EXP + 2, "R3 read response latency", n - 1, W_EXP + 2);
      chk(rsp_rdata == exp, "R9 read data", rsp_rdata, exp);
      check_idle("R1 idle after read");
      @(negedge clk);
      chk(!rsp_valid, "R3 response pulse width", rsp_valid, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R1 watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R1 reset state");
      chk(!rsp_valid, "R1 no response in reset", rsp_valid, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle("R1 idle after reset release");

      for (int i = 0; i < NADDR; i++) do_write(pick_addr(i), pat(pick_addr(i), 8'h3C));
      for (int i = 0; i < NADDR; i++) do_read(pick_addr(i), pat(pick_addr(i), 8'h3C));
      for (int i = 0; i < NADDR; i++) begin
         do_read(pick_addr(i), pat(pick_addr(i), 8'h3C));
         do_write(pick_addr(i), pat(pick_addr(i), 8'hA5));
      end
      for (int i = NADDR - 1; i >= 0; i--) do_read(pick_addr(i), pat(pick_addr(i), 8'hA5));

      // R7: request held and changed while busy must not start a second access
      begin
         int falls0;
         falls0 = we_falls;
         req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h0ABCD; req_wdata = 8'h77;
         while (!req_ready) @(negedge clk);
         @(negedge clk);
         req_addr = 17'h05555; req_wdata = 8'h99;
         for (int k = 0; k < P_EXP + 1; k++) begin
            chk(!req_ready, "R7 ready low while busy", req_ready, 0);
            @(negedge clk);
         end
         req_valid = 1'b0;
         @(negedge clk);
         check_idle("R1 idle after held request");
         chk(we_falls - falls0 == 1, "R7 single write pulse", we_falls - falls0, 1);
         do_read(17'h0ABCD, 8'h77);
         do_read(17'h05555, 8'h5A);
      end

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule